// File: doc/BRIEF.md
# Twin-Port Synchronous RAM

This block is a synchronous memory with two independent access ports. Each port has its own clock, and each can read or write any location. Every port has the following signals:

- an address;
- a main data word with a group of auxiliary bits carried beside it;
- a registered output word;
- a port enable;
- a write enable;
- a synchronous set/reset that loads the output register with a reset value fixed for that port at elaboration.

A stored word is the concatenation of the auxiliary bits (upper) and the main data bits (lower). The auxiliary bits get no parity treatment. They are stored and returned exactly like data.

A write-collision parameter is chosen for each port at elaboration. It sets what the port's output shows in a cycle where that port writes:

- the new word;
- the word that was overwritten;
- the output held unchanged.

When both ports write the same address in the same cycle, the stored result is undefined. Users must avoid that case.

Top module: `twin_port_ram`

## Requirements
- R1: Each port acts only on the rising edge of its own clock. Its output word changes one edge after its inputs are presented, with no combinational path from inputs to outputs.
- R2: While a port's enable is low, that port performs no write and its output holds its value. Its set/reset and write enable are ignored.
- R3: A write, meaning enable and write enable both high at an edge, stores {aux, data} at the address. The word is then readable from either port.
- R4: With enable high, write enable low and set/reset low, the output shows the word stored at the address after the edge.
- R5: Mode value WM_WRITE_FIRST (encoding 0): during a write the output shows the word just written.
- R6: Mode value WM_READ_FIRST (encoding 1): during a write the output shows the word the location held before the write.
- R7: Mode value WM_NO_CHANGE (encoding 2): during a write the output keeps its previous value.
- R8: Set/reset high with enable high loads that port's reset value into the output. This takes priority over read or write data.
- R9: A write requested in the same cycle as set/reset still updates the memory.
- R10: The auxiliary bits are returned unaltered on the auxiliary output. They form bit DATA_W and above of the word, with no parity generation or checking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| sr_a | input | 1 | Port A synchronous output set/reset |
| addr_a | input | ADDR_W | Port A address |
| din_a | input | DATA_W | Port A write data |
| dinx_a | input | AUX_W | Port A auxiliary write bits |
| dout_a | output | DATA_W | Port A registered read data |
| doutx_a | output | AUX_W | Port A registered auxiliary bits |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| sr_b | input | 1 | Port B synchronous output set/reset |
| addr_b | input | ADDR_W | Port B address |
| din_b | input | DATA_W | Port B write data |
| dinx_b | input | AUX_W | Port B auxiliary write bits |
| dout_b | output | DATA_W | Port B registered read data |
| doutx_b | output | AUX_W | Port B registered auxiliary bits |

## Verification
Every result of this block, whether read data, collision-mode output or reset value, is due exactly one rising edge of the issuing port's clock after the inputs are applied. Inputs are driven on the falling edge. Outputs are compared at the next falling edge, which falls after the single register stage has updated. One extra comparison is made just before an edge, after new inputs are applied, to show the output has not moved early. Data written through one port is read back through the other in a later cycle, never in the same cycle, so the undefined same-address collision never arises.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    // Behaviour of a port's output register in a cycle where that port writes.
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    // Source loaded into a port's output register at its clock edge.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_RST   = 2'd1,
        SRC_MEM   = 2'd2,
        SRC_WDATA = 2'd3
    } out_src_e;

    localparam int unsigned NUM_PORTS = 2;

    // Chooses the output register source from the control inputs.
    // Set/reset outranks read and write data. A disabled port holds.
    function automatic out_src_e select_src(
        input wmode_e mode,
        input logic   en,
        input logic   we,
        input logic   sr
    );
        out_src_e s;
        if (!en) begin
            s = SRC_HOLD;
        end else if (sr) begin
            s = SRC_RST;
        end else if (!we) begin
            s = SRC_MEM;
        end else begin
            unique case (mode)
                WM_WRITE_FIRST: s = SRC_WDATA;
                WM_READ_FIRST:  s = SRC_MEM;
                default:        s = SRC_HOLD;
            endcase
        end
        return s;
    endfunction

    // Write-side ownership flag. The bank of the port that wrote an address
    // last is found by comparing the two flags stored for that address.
    // Port 0 makes the flags differ, port 1 makes them equal.
    function automatic logic owner_flag(
        input int   port_idx,
        input logic other_flag
    );
        return (port_idx == 0) ? ~other_flag : other_flag;
    endfunction

endpackage

// File: rtl/tpr_bank.sv
// Storage written by exactly one port clock. Two combinational read taps
// serve the two ports. Each entry carries an ownership flag.
module tpr_bank #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned WORD_W = 9
) (
    input  logic                             clk,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [WORD_W-1:0]                wr_word,
    input  logic                             wr_flag,
    input  logic [tpr_pkg::NUM_PORTS-1:0][ADDR_W-1:0] rd_addr,
    output logic [tpr_pkg::NUM_PORTS-1:0][WORD_W-1:0] rd_word,
    output logic [tpr_pkg::NUM_PORTS-1:0]             rd_flag
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];
    logic [DEPTH-1:0]  flags;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_word;
            flags[wr_addr] <= wr_flag;
        end
    end

    for (genvar t = 0; t < tpr_pkg::NUM_PORTS; t++) begin : g_tap
        assign rd_word[t] = store[rd_addr[t]];
        assign rd_flag[t] = flags[rd_addr[t]];
    end

endmodule

// File: rtl/tpr_port.sv
// Output register and write strobe for one access port.
module tpr_port #(
    parameter int unsigned    WORD_W = 9,
    parameter tpr_pkg::wmode_e MODE  = tpr_pkg::WM_WRITE_FIRST,
    parameter logic [WORD_W-1:0] SRVAL = '0
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic              sr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [WORD_W-1:0] mem_word,
    output logic              wr_fire,
    output logic [WORD_W-1:0] q
);
    import tpr_pkg::*;

    out_src_e src;

    always_comb begin
        src     = select_src(MODE, en, we, sr);
        wr_fire = en & we;
    end

    always_ff @(posedge clk) begin
        unique case (src)
            SRC_RST:   q <= SRVAL;
            SRC_MEM:   q <= mem_word;
            SRC_WDATA: q <= wr_word;
            default:   q <= q;
        endcase
    end

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
    parameter int unsigned     DATA_W = 8,
    parameter int unsigned     AUX_W  = 1,
    parameter int unsigned     ADDR_W = 11,
    parameter tpr_pkg::wmode_e MODE_A = tpr_pkg::WM_WRITE_FIRST,
    parameter tpr_pkg::wmode_e MODE_B = tpr_pkg::WM_WRITE_FIRST,
    parameter logic [DATA_W+AUX_W-1:0] SRVAL_A = '0,
    parameter logic [DATA_W+AUX_W-1:0] SRVAL_B = '0
) (
    input  logic              clk_a,
    input  logic              en_a,
    input  logic              we_a,
    input  logic              sr_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] din_a,
    input  logic [AUX_W-1:0]  dinx_a,
    output logic [DATA_W-1:0] dout_a,
    output logic [AUX_W-1:0]  doutx_a,
    input  logic              clk_b,
    input  logic              en_b,
    input  logic              we_b,
    input  logic              sr_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_b,
    input  logic [AUX_W-1:0]  dinx_b,
    output logic [DATA_W-1:0] dout_b,
    output logic [AUX_W-1:0]  doutx_b
);
    import tpr_pkg::*;

    localparam int unsigned WORD_W = DATA_W + AUX_W;
    localparam int unsigned NP     = NUM_PORTS;

    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic [DATA_W-1:0] dat;
    } word_t;

    logic [NP-1:0]             clk_v, en_v, we_v, sr_v, fire_v, wflag_v;
    logic [NP-1:0][ADDR_W-1:0] addr_v;
    word_t [NP-1:0]            wword_v, oword_v, old_v;

    // Per bank: words and flags seen at each port's address.
    logic [NP-1:0][WORD_W-1:0] bank_word [NP];
    logic [NP-1:0]             bank_flag [NP];

    assign clk_v   = {clk_b, clk_a};
    assign en_v    = {en_b, en_a};
    assign we_v    = {we_b, we_a};
    assign sr_v    = {sr_b, sr_a};
    assign addr_v  = {addr_b, addr_a};
    assign wword_v = {word_t'{aux: dinx_b, dat: din_b},
                      word_t'{aux: dinx_a, dat: din_a}};

    assign {doutx_a, dout_a} = oword_v[0];
    assign {doutx_b, dout_b} = oword_v[1];

    for (genvar p = 0; p < NP; p++) begin : g_port
        localparam wmode_e             P_MODE  = (p == 0) ? MODE_A : MODE_B;
        localparam logic [WORD_W-1:0]  P_SRVAL = (p == 0) ? SRVAL_A : SRVAL_B;
        localparam int unsigned        OTHER   = NP - 1 - p;

        // Flag written with this port's data: set relative to the other
        // bank's flag at the same address so the last writer is recoverable.
        assign wflag_v[p] = owner_flag(p, bank_flag[OTHER][p]);

        tpr_bank #(
            .ADDR_W (ADDR_W),
            .WORD_W (WORD_W)
        ) u_bank (
            .clk     (clk_v[p]),
            .wr_en   (fire_v[p]),
            .wr_addr (addr_v[p]),
            .wr_word (wword_v[p]),
            .wr_flag (wflag_v[p]),
            .rd_addr (addr_v),
            .rd_word (bank_word[p]),
            .rd_flag (bank_flag[p])
        );

        // Resolved current content at this port's address.
        assign old_v[p] = (bank_flag[0][p] != bank_flag[1][p])
                        ? word_t'(bank_word[0][p])
                        : word_t'(bank_word[1][p]);

        tpr_port #(
            .WORD_W (WORD_W),
            .MODE   (P_MODE),
            .SRVAL  (P_SRVAL)
        ) u_port (
            .clk      (clk_v[p]),
            .en       (en_v[p]),
            .we       (we_v[p]),
            .sr       (sr_v[p]),
            .wr_word  (wword_v[p]),
            .mem_word (old_v[p]),
            .wr_fire  (fire_v[p]),
            .q        (oword_v[p])
        );
    end

endmodule

// File: rtl/twin_port_ram_chk.sv
module twin_port_ram_chk #(
    parameter int unsigned     DATA_W = 8,
    parameter int unsigned     AUX_W  = 1,
    parameter int unsigned     ADDR_W = 11,
    parameter tpr_pkg::wmode_e MODE_A = tpr_pkg::WM_WRITE_FIRST,
    parameter tpr_pkg::wmode_e MODE_B = tpr_pkg::WM_WRITE_FIRST,
    parameter logic [DATA_W+AUX_W-1:0] SRVAL_A = '0,
    parameter logic [DATA_W+AUX_W-1:0] SRVAL_B = '0
) (
    input logic              clk_a,
    input logic              en_a,
    input logic              we_a,
    input logic              sr_a,
    input logic [DATA_W-1:0] din_a,
    input logic [AUX_W-1:0]  dinx_a,
    input logic [DATA_W-1:0] dout_a,
    input logic [AUX_W-1:0]  doutx_a,
    input logic              clk_b,
    input logic              en_b,
    input logic              we_b,
    input logic              sr_b,
    input logic [DATA_W-1:0] din_b,
    input logic [AUX_W-1:0]  dinx_b,
    input logic [DATA_W-1:0] dout_b,
    input logic [AUX_W-1:0]  doutx_b
);
    import tpr_pkg::*;

    // Properties start only after two edges of each clock, so outputs
    // have been loaded at least once.
    logic [1:0] age_a = 2'd0;
    logic [1:0] age_b = 2'd0;
    logic armed_a, armed_b;

    always_ff @(posedge clk_a) if (age_a != 2'd2) age_a <= age_a + 2'd1;
    always_ff @(posedge clk_b) if (age_b != 2'd2) age_b <= age_b + 2'd1;
    assign armed_a = (age_a == 2'd2);
    assign armed_b = (age_b == 2'd2);

    // R2: disabled port holds its output
    a_r2_hold_a: assert property (@(posedge clk_a) disable iff (!armed_a)
        !en_a |=> $stable({doutx_a, dout_a}));
    a_r2_hold_b: assert property (@(posedge clk_b) disable iff (!armed_b)
        !en_b |=> $stable({doutx_b, dout_b}));

    // R8: set/reset loads the port's reset value
    a_r8_srval_a: assert property (@(posedge clk_a) disable iff (!armed_a)
        (en_a && sr_a) |=> ({doutx_a, dout_a} == SRVAL_A));
    a_r8_srval_b: assert property (@(posedge clk_b) disable iff (!armed_b)
        (en_b && sr_b) |=> ({doutx_b, dout_b} == SRVAL_B));

    // R5: write-first echoes the written word
    a_r5_wfirst_a: assert property (@(posedge clk_a) disable iff (!armed_a)
        (MODE_A == WM_WRITE_FIRST && en_a && we_a && !sr_a)
        |=> ({doutx_a, dout_a} == $past({dinx_a, din_a})));
    a_r5_wfirst_b: assert property (@(posedge clk_b) disable iff (!armed_b)
        (MODE_B == WM_WRITE_FIRST && en_b && we_b && !sr_b)
        |=> ({doutx_b, dout_b} == $past({dinx_b, din_b})));

    // R7: no-change keeps the output during a write
    a_r7_nochange_a: assert property (@(posedge clk_a) disable iff (!armed_a)
        (MODE_A == WM_NO_CHANGE && en_a && we_a && !sr_a)
        |=> $stable({doutx_a, dout_a}));
    a_r7_nochange_b: assert property (@(posedge clk_b) disable iff (!armed_b)
        (MODE_B == WM_NO_CHANGE && en_b && we_b && !sr_b)
        |=> $stable({doutx_b, dout_b}));

endmodule

bind twin_port_ram twin_port_ram_chk #(
    .DATA_W (DATA_W), .AUX_W (AUX_W), .ADDR_W (ADDR_W),
    .MODE_A (MODE_A), .MODE_B (MODE_B),
    .SRVAL_A (SRVAL_A), .SRVAL_B (SRVAL_B)
) u_chk (
    .clk_a (clk_a), .en_a (en_a), .we_a (we_a), .sr_a (sr_a),
    .din_a (din_a), .dinx_a (dinx_a), .dout_a (dout_a), .doutx_a (doutx_a),
    .clk_b (clk_b), .en_b (en_b), .we_b (we_b), .sr_b (sr_b),
    .din_b (din_b), .dinx_b (dinx_b), .dout_b (dout_b), .doutx_b (doutx_b)
);

// File: tb/twin_port_ram_tb.sv
`timescale 1ns/1ps
module twin_port_ram_tb;
    import tpr_pkg::*;

    localparam int DW = 8;
    localparam int XW = 1;
    localparam int AW = 4;
    localparam int N  = 1 << AW;
    localparam logic [8:0] SA  = 9'h1A5;
    localparam logic [8:0] SB  = 9'h05A;
    localparam logic [8:0] NSA = 9'h133;
    localparam logic [8:0] NSB = 9'h0CC;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    always #2.5 clk_a = ~clk_a;
    always #2.5 clk_b = ~clk_b;

    logic          en_a, we_a, sr_a, en_b, we_b, sr_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [DW-1:0] din_a, din_b, dout_a, dout_b, ndout_a, ndout_b;
    logic [XW-1:0] dinx_a, dinx_b, doutx_a, doutx_b, ndoutx_a, ndoutx_b;
    logic [8:0]    qa, qb, nqa, nqb;

    assign qa  = {doutx_a, dout_a};
    assign qb  = {doutx_b, dout_b};
    assign nqa = {ndoutx_a, ndout_a};
    assign nqb = {ndoutx_b, ndout_b};

    // Port A write-first, port B read-first
    twin_port_ram #(
        .DATA_W(DW), .AUX_W(XW), .ADDR_W(AW),
        .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST),
        .SRVAL_A(SA), .SRVAL_B(SB)
    ) u_dut (
        .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .sr_a(sr_a), .addr_a(addr_a),
        .din_a(din_a), .dinx_a(dinx_a), .dout_a(dout_a), .doutx_a(doutx_a),
        .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .sr_b(sr_b), .addr_b(addr_b),
        .din_b(din_b), .dinx_b(dinx_b), .dout_b(dout_b), .doutx_b(doutx_b)
    );

    // Both ports no-change, same stimulus
    twin_port_ram #(
        .DATA_W(DW), .AUX_W(XW), .ADDR_W(AW),
        .MODE_A(WM_NO_CHANGE), .MODE_B(WM_NO_CHANGE),
        .SRVAL_A(NSA), .SRVAL_B(NSB)
    ) u_dut_nc (
        .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .sr_a(sr_a), .addr_a(addr_a),
        .din_a(din_a), .dinx_a(dinx_a), .dout_a(ndout_a), .doutx_a(ndoutx_a),
        .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .sr_b(sr_b), .addr_b(addr_b),
        .din_b(din_b), .dinx_b(dinx_b), .dout_b(ndout_b), .doutx_b(ndoutx_b)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    function automatic logic [8:0] pat(input int a, input int k);
        return 9'((a * 37 + k * 101 + 5) % 512);
    endfunction

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_a(input logic e, input logic w, input logic s,
                         input int ad, input logic [8:0] wd);
        en_a = e; we_a = w; sr_a = s; addr_a = AW'(ad);
        {dinx_a, din_a} = wd;
    endtask

    task automatic set_b(input logic e, input logic w, input logic s,
                         input int ad, input logic [8:0] wd);
        en_b = e; we_b = w; sr_b = s; addr_b = AW'(ad);
        {dinx_b, din_b} = wd;
    endtask

    task automatic tick;
        @(posedge clk_a);
        @(negedge clk_a);
    endtask

    initial begin
        // R8: set/reset both ports before the first edge
        set_a(1, 0, 1, 0, 9'h0);
        set_b(1, 0, 1, 0, 9'h0);
        tick;
        chk("R8 reset A", qa, SA);
        chk("R8 reset B", qb, SB);
        chk("R8 reset nc A", nqa, NSA);
        chk("R8 reset nc B", nqb, NSB);
        set_b(0, 0, 0, 0, 9'h0);

        // R5 / R7: port A writes every address; B disabled (R2)
        for (int a = 0; a < N; a++) begin
            set_a(1, 1, 0, a, pat(a, 1));
            tick;
            chk("R5 write-first echo", qa, pat(a, 1));
            chk("R7 no-change hold A", nqa, NSA);
            chk("R2 idle B holds", qb, SB);
        end
        set_a(0, 0, 0, 0, 9'h0);

        // R3 / R4 / R10: port B reads back A's data, aux bit included
        for (int a = 0; a < N; a++) begin
            set_b(1, 0, 0, a, 9'h0);
            tick;
            chk("R3 cross-port read B", qb, pat(a, 1));
            chk("R10 aux bits nc B", nqb, pat(a, 1));
        end
        chk("R2 idle A holds", qa, pat(N - 1, 1));

        // R6 / R7: port B overwrites every address
        for (int a = 0; a < N; a++) begin
            set_b(1, 1, 0, a, pat(a, 2));
            tick;
            chk("R6 read-first old word", qb, pat(a, 1));
            chk("R7 no-change hold B", nqb, pat(N - 1, 1));
        end
        set_b(0, 0, 0, 0, 9'h0);

        // R4: port A reads the new contents
        for (int a = 0; a < N; a++) begin
            set_a(1, 0, 0, a, 9'h0);
            tick;
            chk("R4 read A", qa, pat(a, 2));
            chk("R4 read nc A", nqa, pat(a, 2));
        end

        // R2: disabled port ignores write and set/reset
        set_a(0, 1, 1, 0, 9'h000);
        tick;
        chk("R2 disabled hold A", qa, pat(N - 1, 2));
        set_a(1, 0, 0, 0, 9'h0);
        tick;
        chk("R2 no write when disabled", qa, pat(0, 2));

        // R8 / R9: set/reset with write
        set_a(1, 1, 1, 5, 9'h0F0);
        tick;
        chk("R8 srval over write A", qa, SA);
        chk("R8 srval over write nc A", nqa, NSA);
        set_a(0, 0, 0, 0, 9'h0);
        set_b(1, 0, 0, 5, 9'h0);
        tick;
        chk("R9 write during sr B", qb, 9'h0F0);
        chk("R9 write during sr nc B", nqb, 9'h0F0);

        // R10: aux bit set alone, then cleared with data all ones
        set_b(0, 0, 0, 0, 9'h0);
        set_a(1, 1, 0, 9, 9'h100);
        tick;
        set_a(1, 1, 0, 10, 9'h0FF);
        tick;
        set_a(0, 0, 0, 0, 9'h0);
        set_b(1, 0, 0, 9, 9'h0);
        tick;
        chk("R10 aux only", qb, 9'h100);
        set_b(1, 0, 0, 10, 9'h0);
        tick;
        chk("R10 data only", qb, 9'h0FF);

        // R1: no change before the edge, new value after it
        set_a(1, 0, 0, 7, 9'h0);
        #1;
        chk("R1 no early change", qa, pat(10, 0) & 9'h0 | 9'h0FF);
        tick;
        chk("R1 one-edge latency", qa, pat(7, 2));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule